// File: doc/BRIEF.md
# Global Timer with Self-Advancing Comparator

A memory-mapped global timer built around a 64-bit free-running counter and one 64-bit comparator. When the comparator is enabled and the counter becomes equal to the full compare value, an interrupt status bit is set. The interrupt output is that status bit gated by an enable bit. With auto-increment turned on, the comparator adds a programmed 32-bit step to itself after every match, which gives a fixed-period interrupt. With auto-increment off, the comparator fires once.

Software reaches the block through a simple 32-bit register bus. Each 64-bit quantity is split into a lower and an upper word. Software reads the counter as upper, then lower, then upper again, and retries when the two upper values differ. The counter therefore needs no snapshot latch, but its carry into the upper word must be clean.

Every write to a counter half, a compare half, the step register or the control register raises a sticky write-done flag. That flag appears a fixed two cycles after the bus write, which models synchronisation delay. Each flag is cleared by writing 1 to its bit.

Top module: `gtimer_top`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: While control bit 8 (run) is set, the counter grows by exactly one per clock. While it is clear, the counter holds its value.
- R3: The counter's lower word at 0x100 and upper word at 0x104 can be read and written. When the lower word wraps from 0xFFFFFFFF, the upper word increments.
- R4: The interrupt status bit (0x244 bit 0) is set when the comparator is enabled (control bit 0) and the full 64-bit counter equals the compare value (0x200 lower, 0x204 upper). It is set in the cycle after the counter reaches that value, and once per match. It is not set when the upper words differ or when the comparator is disabled.
- R5: With auto-increment (control bit 1) clear, the compare value is unchanged after a match, and no further match occurs once the counter has passed it.
- R6: With auto-increment set, each match adds the zero-extended step at 0x208 to the compare value, so the interrupt repeats every step cycles.
- R7: Writing 1 to 0x244 bit 0 clears the status bit. `irq_o` equals the status bit ANDed with the enable at 0x248 bit 0.
- R8: A write to 0x100 or 0x104 sets bit 0 or bit 1 of 0x110. A write to 0x200, 0x204, 0x208 or 0x240 sets bit 0, 1, 2 or 16 of 0x24C. Each flag becomes visible after the second clock edge, counting the edge that takes the write. Writing 1 to a flag bit clears that flag and leaves the other flags unchanged.
- R9: Unmapped offsets read zero, and writes to them change no register.
- R10: The control register reads back only bits 8, 1 and 0. The interrupt enable register reads back only bit 0. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Compare interrupt |

## Verification
The comparator is tested with four patterns. A one-shot match with the counter started from zero pins the exact cycle in which status rises. A compare value whose upper word differs from the counter's shows that the whole 64 bits are compared. A disabled comparator separates the enable gating from the equality test. A periodic run with a step of 25 separates self-advance from one-shot behaviour, both by reading back the advanced compare value and by the timing of the second event. Counter runs of known length, including one across the lower-word wrap, tell a correct carry apart from a dropped or doubled one. The write-done flags are sampled one and two cycles after a write, which separates the correct latency from an off-by-one delay.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;
  parameter int unsigned GT_DW = 32;
  parameter int unsigned GT_AW = 12;

  localparam logic [GT_AW-1:0] OFS_CNT_LO = 12'h100;
  localparam logic [GT_AW-1:0] OFS_CNT_HI = 12'h104;
  localparam logic [GT_AW-1:0] OFS_CNT_WS = 12'h110;
  localparam logic [GT_AW-1:0] OFS_CMP_LO = 12'h200;
  localparam logic [GT_AW-1:0] OFS_CMP_HI = 12'h204;
  localparam logic [GT_AW-1:0] OFS_STEP   = 12'h208;
  localparam logic [GT_AW-1:0] OFS_CTRL   = 12'h240;
  localparam logic [GT_AW-1:0] OFS_ISTS   = 12'h244;
  localparam logic [GT_AW-1:0] OFS_IEN    = 12'h248;
  localparam logic [GT_AW-1:0] OFS_GWS    = 12'h24C;

  localparam int unsigned CTRL_RUN_BIT  = 8;
  localparam int unsigned CTRL_AUTO_BIT = 1;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned GWS_CTRL_BIT  = 16;

  // write-done source indices
  localparam int unsigned WS_CNT_LO = 0;
  localparam int unsigned WS_CNT_HI = 1;
  localparam int unsigned WS_CMP_LO = 2;
  localparam int unsigned WS_CMP_HI = 3;
  localparam int unsigned WS_STEP   = 4;
  localparam int unsigned WS_CTRL   = 5;
  localparam int unsigned WS_N      = 6;

  typedef struct packed {
    logic run;
    logic auto_inc;
    logic cmp_en;
  } gt_ctrl_t;
endpackage

// File: rtl/gtimer_counter.sv
module gtimer_counter #(
  parameter int unsigned DW = 32,
  localparam int unsigned CW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = run_i ? cnt_q + CW'(1) : cnt_q;
    if (wr_lo_i) cnt_d[DW-1:0]  = wdata_i;
    if (wr_hi_i) cnt_d[CW-1:DW] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/gtimer_comparator.sv
module gtimer_comparator #(
  parameter int unsigned DW = 32,
  localparam int unsigned CW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          auto_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic          wr_step_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] cmp_o,
  output logic [DW-1:0] step_o,
  output logic          hit_o
);
  logic [CW-1:0] cmp_q, cmp_d;
  logic [DW-1:0] step_q;
  logic          eq, eq_q;

  assign eq    = en_i && (cnt_i == cmp_q);
  assign hit_o = eq && !eq_q;   // one event per match

  always_comb begin
    cmp_d = cmp_q;
    if (hit_o && auto_i) cmp_d = cmp_q + {{DW{1'b0}}, step_q};
    if (wr_lo_i) cmp_d[DW-1:0]  = wdata_i;
    if (wr_hi_i) cmp_d[CW-1:DW] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      step_q <= '0;
      eq_q   <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      eq_q  <= eq;
      if (wr_step_i) step_q <= wdata_i;
    end
  end

  assign cmp_o  = cmp_q;
  assign step_o = step_q;
endmodule

// File: rtl/gtimer_wstat.sv
module gtimer_wstat #(
  parameter int unsigned N   = 6,
  parameter int unsigned LAT = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] arrive;
  logic [N-1:0] flag_q;

  generate
    if (LAT <= 1) begin : g_direct
      assign arrive = set_i;
    end else begin : g_pipe
      logic [N-1:0] stg_q [LAT-1];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < int'(LAT) - 1; i++) stg_q[i] <= '0;
        end else begin
          stg_q[0] <= set_i;
          for (int i = 1; i < int'(LAT) - 1; i++) stg_q[i] <= stg_q[i-1];
        end
      end
      assign arrive = stg_q[LAT-2];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | arrive;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gtimer_regs.sv
module gtimer_regs
  import gtimer_pkg::*;
#(
  parameter int unsigned DW = GT_DW,
  parameter int unsigned AW = GT_AW,
  localparam int unsigned CW = 2 * DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            hit_i,
  input  logic [CW-1:0]   cnt_i,
  input  logic [CW-1:0]   cmp_i,
  input  logic [DW-1:0]   step_i,
  input  logic [WS_N-1:0] wflag_i,
  output logic [DW-1:0]   rdata_o,
  output gt_ctrl_t        ctrl_o,
  output logic            ists_o,
  output logic            ien_o,
  output logic [WS_N-1:0] wset_o,
  output logic [WS_N-1:0] wclr_o
);
  logic     we;
  gt_ctrl_t ctrl_q;
  logic     ists_q, ien_q;

  assign we = sel_i && wr_i;

  always_comb begin
    wset_o = '0;
    wclr_o = '0;
    if (we) begin
      unique case (addr_i)
        OFS_CNT_LO: wset_o[WS_CNT_LO] = 1'b1;
        OFS_CNT_HI: wset_o[WS_CNT_HI] = 1'b1;
        OFS_CMP_LO: wset_o[WS_CMP_LO] = 1'b1;
        OFS_CMP_HI: wset_o[WS_CMP_HI] = 1'b1;
        OFS_STEP:   wset_o[WS_STEP]   = 1'b1;
        OFS_CTRL:   wset_o[WS_CTRL]   = 1'b1;
        OFS_CNT_WS: begin
          wclr_o[WS_CNT_LO] = wdata_i[0];
          wclr_o[WS_CNT_HI] = wdata_i[1];
        end
        OFS_GWS: begin
          wclr_o[WS_CMP_LO] = wdata_i[0];
          wclr_o[WS_CMP_HI] = wdata_i[1];
          wclr_o[WS_STEP]   = wdata_i[2];
          wclr_o[WS_CTRL]   = wdata_i[GWS_CTRL_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ists_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (we && addr_i == OFS_CTRL) begin
        ctrl_q.run      <= wdata_i[CTRL_RUN_BIT];
        ctrl_q.auto_inc <= wdata_i[CTRL_AUTO_BIT];
        ctrl_q.cmp_en   <= wdata_i[CTRL_EN_BIT];
      end
      if (we && addr_i == OFS_IEN) ien_q <= wdata_i[0];
      // a new match wins over a simultaneous clear
      ists_q <= (ists_q && !(we && addr_i == OFS_ISTS && wdata_i[0])) || hit_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !wr_i) begin
      unique case (addr_i)
        OFS_CNT_LO: rdata_o = cnt_i[DW-1:0];
        OFS_CNT_HI: rdata_o = cnt_i[CW-1:DW];
        OFS_CNT_WS: rdata_o[1:0] = {wflag_i[WS_CNT_HI], wflag_i[WS_CNT_LO]};
        OFS_CMP_LO: rdata_o = cmp_i[DW-1:0];
        OFS_CMP_HI: rdata_o = cmp_i[CW-1:DW];
        OFS_STEP:   rdata_o = step_i;
        OFS_CTRL: begin
          rdata_o[CTRL_RUN_BIT]  = ctrl_q.run;
          rdata_o[CTRL_AUTO_BIT] = ctrl_q.auto_inc;
          rdata_o[CTRL_EN_BIT]   = ctrl_q.cmp_en;
        end
        OFS_ISTS:   rdata_o[0] = ists_q;
        OFS_IEN:    rdata_o[0] = ien_q;
        OFS_GWS: begin
          rdata_o[0] = wflag_i[WS_CMP_LO];
          rdata_o[1] = wflag_i[WS_CMP_HI];
          rdata_o[2] = wflag_i[WS_STEP];
          rdata_o[GWS_CTRL_BIT] = wflag_i[WS_CTRL];
        end
        default: ;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign ists_o = ists_q;
  assign ien_o  = ien_q;
endmodule

// File: rtl/gtimer_top.sv
module gtimer_top
  import gtimer_pkg::*;
#(
  parameter int unsigned DW        = GT_DW,
  parameter int unsigned AW        = GT_AW,
  parameter int unsigned WSTAT_LAT = 2,
  localparam int unsigned CW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_sel_i,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o
);
  gt_ctrl_t        ctrl;
  logic [CW-1:0]   cnt_q, cmp_q;
  logic [DW-1:0]   step_q;
  logic            hit, int_sts, int_en;
  logic [WS_N-1:0] wset, wclr, wflag;

  gtimer_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .sel_i(bus_sel_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .hit_i(hit), .cnt_i(cnt_q), .cmp_i(cmp_q), .step_i(step_q), .wflag_i(wflag),
    .rdata_o(bus_rdata_o), .ctrl_o(ctrl), .ists_o(int_sts), .ien_o(int_en),
    .wset_o(wset), .wclr_o(wclr)
  );

  gtimer_counter #(.DW(DW)) u_cnt (
    .clk_i, .rst_ni, .run_i(ctrl.run),
    .wr_lo_i(wset[WS_CNT_LO]), .wr_hi_i(wset[WS_CNT_HI]),
    .wdata_i(bus_wdata_i), .cnt_o(cnt_q)
  );

  gtimer_comparator #(.DW(DW)) u_cmp (
    .clk_i, .rst_ni, .en_i(ctrl.cmp_en), .auto_i(ctrl.auto_inc),
    .wr_lo_i(wset[WS_CMP_LO]), .wr_hi_i(wset[WS_CMP_HI]), .wr_step_i(wset[WS_STEP]),
    .wdata_i(bus_wdata_i), .cnt_i(cnt_q),
    .cmp_o(cmp_q), .step_o(step_q), .hit_o(hit)
  );

  gtimer_wstat #(.N(WS_N), .LAT(WSTAT_LAT)) u_ws (
    .clk_i, .rst_ni, .set_i(wset), .clr_i(wclr), .flag_o(wflag)
  );

  assign irq_o = int_sts && int_en;
endmodule

// File: rtl/gtimer_chk.sv
module gtimer_chk
  import gtimer_pkg::*;
#(
  parameter int unsigned DW  = GT_DW,
  parameter int unsigned AW  = GT_AW,
  parameter int unsigned LAT = 2,
  localparam int unsigned CW = 2 * DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_sel_i,
  input logic          bus_wr_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [DW-1:0] bus_wdata_i,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] cmp_q,
  input gt_ctrl_t      ctrl,
  input logic          int_sts,
  input logic [WS_N-1:0] wflag
);
  logic we, cnt_wr, cmp_wr, ctrl_wr, sts_clr, ctrl_recent;
  logic [LAT-1:0] hist_q;

  assign we      = bus_sel_i && bus_wr_i;
  assign cnt_wr  = we && (bus_addr_i == OFS_CNT_LO || bus_addr_i == OFS_CNT_HI);
  assign cmp_wr  = we && (bus_addr_i == OFS_CMP_LO || bus_addr_i == OFS_CMP_HI);
  assign ctrl_wr = we && bus_addr_i == OFS_CTRL;
  assign sts_clr = we && bus_addr_i == OFS_ISTS && bus_wdata_i[0];
  assign ctrl_recent = ctrl_wr || (|hist_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= (hist_q << 1) | LAT'(ctrl_wr);
  end

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.run && !cnt_wr |=> cnt_q == $past(cnt_q) + CW'(1));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.run && !cnt_wr |=> $stable(cnt_q));

  a_r4_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_sts) |-> $past(ctrl.cmp_en && cnt_q == cmp_q));

  a_r5_cmp_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.auto_inc && !cmp_wr |=> $stable(cmp_q));

  a_r7_sts_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_sts && !sts_clr |=> int_sts);

  a_r8_ctrl_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wflag[WS_CTRL]) |-> $past(ctrl_recent));
endmodule

bind gtimer_top gtimer_chk #(.DW(DW), .AW(AW), .LAT(WSTAT_LAT)) u_chk (
  .clk_i, .rst_ni, .bus_sel_i, .bus_wr_i, .bus_addr_i, .bus_wdata_i,
  .cnt_q, .cmp_q, .ctrl, .int_sts, .wflag
);

// File: tb/gtimer_tb.sv
module gtimer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  gtimer_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called in the low phase; one rising edge takes the write
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 cnt_lo", 12'h100, 0);
    rd_chk("R1 cnt_hi", 12'h104, 0);
    rd_chk("R1 cmp_lo", 12'h200, 0);
    rd_chk("R1 ctrl",   12'h240, 0);
    rd_chk("R1 ists",   12'h244, 0);
    rd_chk("R1 gws",    12'h24C, 0);
    rd_chk("R1 cws",    12'h110, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_count;
    bus_wr(12'h240, 32'h100);
    wait_cyc(10);
    bus_wr(12'h240, 32'h0);
    rd_chk("R2 count 11", 12'h100, 11);
    wait_cyc(8);
    rd_chk("R2 hold", 12'h100, 11);
  endtask

  task automatic t_rollover;
    bus_wr(12'h100, 32'hFFFF_FFFD);
    bus_wr(12'h104, 32'h7);
    rd_chk("R3 wr lo", 12'h100, 32'hFFFF_FFFD);
    rd_chk("R3 wr hi", 12'h104, 32'h7);
    bus_wr(12'h240, 32'h100);
    wait_cyc(5);
    bus_wr(12'h240, 32'h0);
    rd_chk("R3 carry hi", 12'h104, 32'h8);
    rd_chk("R3 wrap lo",  12'h100, 32'h3);
  endtask

  task automatic zero_cnt;
    bus_wr(12'h240, 32'h0);
    bus_wr(12'h100, 32'h0);
    bus_wr(12'h104, 32'h0);
    bus_wr(12'h244, 32'h1);
  endtask

  task automatic t_oneshot;
    zero_cnt();
    bus_wr(12'h200, 32'd20);
    bus_wr(12'h204, 32'd0);
    bus_wr(12'h248, 32'h1);
    bus_wr(12'h240, 32'h101);
    wait_cyc(20);
    rd_chk("R4 not yet", 12'h244, 0);
    wait_cyc(1);
    rd_chk("R4 match", 12'h244, 1);
    chk("R7 irq on", {31'b0, irq}, 1);
    rd_chk("R5 cmp kept", 12'h200, 32'd20);
    bus_wr(12'h248, 32'h0);
    chk("R7 irq masked", {31'b0, irq}, 0);
    rd_chk("R7 sts kept", 12'h244, 1);
    bus_wr(12'h248, 32'h1);
    bus_wr(12'h244, 32'h1);
    rd_chk("R7 cleared", 12'h244, 0);
    chk("R7 irq off", {31'b0, irq}, 0);
    wait_cyc(40);
    rd_chk("R5 no repeat", 12'h244, 0);
  endtask

  task automatic t_hi_mismatch;
    zero_cnt();
    bus_wr(12'h200, 32'd10);
    bus_wr(12'h204, 32'd1);
    bus_wr(12'h240, 32'h101);
    wait_cyc(30);
    rd_chk("R4 upper differs", 12'h244, 0);
  endtask

  task automatic t_disabled;
    zero_cnt();
    bus_wr(12'h200, 32'd10);
    bus_wr(12'h204, 32'd0);
    bus_wr(12'h240, 32'h100);
    wait_cyc(30);
    rd_chk("R4 cmp disabled", 12'h244, 0);
  endtask

  task automatic t_periodic;
    zero_cnt();
    bus_wr(12'h200, 32'd10);
    bus_wr(12'h204, 32'd0);
    bus_wr(12'h208, 32'd25);
    bus_wr(12'h240, 32'h103);
    wait_cyc(15);
    rd_chk("R6 first", 12'h244, 1);
    rd_chk("R6 advanced", 12'h200, 32'd35);
    bus_wr(12'h244, 32'h1);
    wait_cyc(18);
    rd_chk("R6 gap", 12'h244, 0);
    wait_cyc(2);
    rd_chk("R6 second", 12'h244, 1);
    rd_chk("R6 advanced again", 12'h200, 32'd60);
    zero_cnt();
  endtask

  task automatic t_wstat;
    bus_wr(12'h24C, 32'h0001_0007);
    bus_wr(12'h110, 32'h3);
    rd_chk("R8 all clear", 12'h24C, 0);
    bus_wr(12'h208, 32'd5);
    rd_chk("R8 step early", 12'h24C, 0);
    wait_cyc(1);
    rd_chk("R8 step flag", 12'h24C, 32'h4);
    bus_wr(12'h204, 32'd0);
    wait_cyc(1);
    rd_chk("R8 cmp hi flag", 12'h24C, 32'h6);
    bus_wr(12'h24C, 32'h4);
    rd_chk("R8 w1c one bit", 12'h24C, 32'h2);
    bus_wr(12'h240, 32'h0);
    wait_cyc(1);
    rd_chk("R8 ctrl flag", 12'h24C, 32'h0001_0002);
    bus_wr(12'h104, 32'd0);
    rd_chk("R8 cnt early", 12'h110, 0);
    wait_cyc(1);
    rd_chk("R8 cnt hi flag", 12'h110, 32'h2);
  endtask

  task automatic t_unmapped;
    bus_wr(12'h100, 32'h1234_5678);
    bus_wr(12'h108, 32'hFFFF_FFFF);
    bus_wr(12'h300, 32'hFFFF_FFFF);
    rd_chk("R9 read zero", 12'h108, 0);
    rd_chk("R9 read zero hi", 12'h300, 0);
    rd_chk("R9 cnt untouched", 12'h100, 32'h1234_5678);
    rd_chk("R9 ctrl untouched", 12'h240, 0);
  endtask

  task automatic t_ctrl_bits;
    bus_wr(12'h240, 32'hFFFF_FFFF);
    rd_chk("R10 ctrl bits", 12'h240, 32'h103);
    bus_wr(12'h240, 32'h0);
    bus_wr(12'h248, 32'hFFFF_FFFF);
    rd_chk("R10 ien bits", 12'h248, 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_rollover();
    t_oneshot();
    t_hi_mismatch();
    t_disabled();
    t_periodic();
    t_wstat();
    t_unmapped();
    t_ctrl_bits();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule